// File: doc/BRIEF.md
# Selectable-Clock Timer Counter Channel

This block is one channel of a general-purpose timer. A 16-bit up-counter advances on count-enable events taken from one of eight sources: four internal divisions of the system clock (by 1, 4, 16 and 64) or four external clock pins. An 8-bit control word picks the source, the edge of that source that counts (rising, falling or both), and the event that returns the counter to zero.

The clear event can be a match or capture strobe from any one of four companion general registers (named A to D here), or a synchronous-clear pulse arriving from a neighbouring channel. A clear chosen for register C or D is blocked while that register serves as a buffer. When this channel clears itself from a register event and synchronous operation is enabled, it sends a one-cycle clear pulse out to the other channels.

External pins are asynchronous. They are resynchronised with two flops in the system clock domain and then edge-detected, so the counter advances at most once per system clock.

Top module: `tmr_channel`

## Requirements
- R1: After reset the counter reads 0 and the control word is 0. The counter then advances by one on every system clock and never clears, whatever the event strobes do.
- R2: Control bits [2:0] = 000, 001, 010, 011 select the internal clock divided by 1, 4, 16, 64. Over any 64 consecutive system clocks the counter advances by 64, 16, 4 and 1.
- R3: Control bits [2:0] = 100, 101, 110, 111 select external pin extClk[0], [1], [2], [3]. Activity on an unselected pin does not change the counter.
- R4: Control bits [4:3] select the counted edge: 00 rising, 01 falling, 1x both. With an internal source every enable pulse counts once, whatever the edge setting.
- R5: The counter wraps from 0xFFFF to 0x0000.
- R6: Control bits [7:5] select the clear source. 001 selects a matchEvt[0] (A) event and 010 selects matchEvt[1] (B). 101 selects matchEvt[2] (C) and 110 selects matchEvt[3] (D). 011 and 111 select syncClrIn. 000 and 100 never clear. An event from an unselected source does not clear.
- R7: With source C selected, a C event does not clear while bufMode[0] is 1. With source D selected, a D event does not clear while bufMode[1] is 1.
- R8: syncClrIn clears the counter only while syncEn is 1.
- R9: A clear seen at a clock edge sets the counter to 0 at that edge, even if an increment is due in the same cycle.
- R10: When a register event (A to D) clears the counter while syncEn is 1, syncClrOut is 1 for exactly the following cycle. It stays 0 for clears that come from syncClrIn and whenever syncEn is 0.
- R11: A rising change on the selected external pin, with edge setting 00, shows on the counter at the third system clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Control word write strobe |
| cfgWrData | input | 8 | Control word write data |
| syncEn | input | 1 | Synchronous-operation enable for this channel |
| extClk | input | 4 | External clock pins A to D (asynchronous) |
| matchEvt | input | 4 | Match/capture event strobes for registers A to D |
| bufMode | input | 2 | Buffer-mode flags: bit 0 for register C, bit 1 for register D |
| syncClrIn | input | 1 | Synchronous-clear pulse from another channel |
| cntVal | output | 16 | Counter value |
| syncClrOut | output | 1 | One-cycle clear pulse to other channels |

## Verification
The bench goes after clear priority: a design that let the increment win would show 1 instead of 0 after a clear. It checks the buffer-mode block on C and D; a design that ignored it would zero the counter on a buffered register's strobe. It checks the syncEn gate on the incoming sync clear, the exact three-edge latency of an external pin, and edge counts in falling and both-edge modes, where a swapped edge decoder yields wrong totals. It also checks the 0xFFFF wrap and the divider ratios, measured over 64-cycle windows so the prescaler phase does not matter. Finally, it checks that syncClrOut stays low for sync-sourced clears, since echoing those would make channels keep clearing each other.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int CTRL_W = 8;

  typedef struct packed {
    logic countEn;
    logic clearReq;
    logic regClear;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
`timescale 1ns/1ps
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int NUM_INT = 4,
  parameter int NUM_EXT = 4,
  parameter int NUM_GR  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [CTRL_W-1:0]   cfgWrData,
  input  logic                syncEn,
  input  logic [NUM_EXT-1:0]  extClk,
  input  logic [NUM_GR-1:0]   matchEvt,
  input  logic [1:0]          bufMode,
  input  logic                syncClrIn,
  output tmrStrobe_t          strobe,
  output logic                syncClrOut
);
  localparam int PRE_W = 2 * (NUM_INT - 1);
  localparam int SEL_W = $clog2(NUM_EXT);

  logic [CTRL_W-1:0] ctrlReg;
  logic [PRE_W-1:0]  preDiv;
  logic [NUM_INT-1:0] tick;
  logic [2:0]        syncSh [NUM_EXT];
  logic [NUM_EXT-1:0] extRise, extFall;
  logic [2:0]        srcSel, clrSel;
  logic [1:0]        edgeSel;
  logic              extEdge, regClr, anyClr;

  assign srcSel  = ctrlReg[2:0];
  assign edgeSel = ctrlReg[4:3];
  assign clrSel  = ctrlReg[7:5];

  always_ff @(posedge clk) begin
    if (!rstN) ctrlReg <= '0;
    else if (cfgWrEn) ctrlReg <= cfgWrData;
  end

  // free-running divider, never restarted on a source change
  always_ff @(posedge clk) begin
    if (!rstN) preDiv <= '0;
    else preDiv <= preDiv + 1'b1;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_INT; gi++) begin : g_tick
      if (gi == 0) begin : g_full
        assign tick[gi] = 1'b1;
      end else begin : g_div
        assign tick[gi] = &preDiv[2*gi-1:0];
      end
    end
    for (gi = 0; gi < NUM_EXT; gi++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) syncSh[gi] <= '0;
        else syncSh[gi] <= {syncSh[gi][1:0], extClk[gi]};
      end
      assign extRise[gi] = syncSh[gi][1] & ~syncSh[gi][2];
      assign extFall[gi] = ~syncSh[gi][1] & syncSh[gi][2];
    end
  endgenerate

  always_comb begin
    if (edgeSel[1])      extEdge = extRise[srcSel[SEL_W-1:0]] | extFall[srcSel[SEL_W-1:0]];
    else if (edgeSel[0]) extEdge = extFall[srcSel[SEL_W-1:0]];
    else                 extEdge = extRise[srcSel[SEL_W-1:0]];
  end

  always_comb begin
    regClr = 1'b0;
    anyClr = 1'b0;
    unique case (clrSel)
      3'b001: regClr = matchEvt[0];
      3'b010: regClr = matchEvt[1];
      3'b101: regClr = matchEvt[2] & ~bufMode[0];
      3'b110: regClr = matchEvt[3] & ~bufMode[1];
      3'b011, 3'b111: anyClr = syncClrIn & syncEn;
      default: ;
    endcase
  end

  assign strobe.countEn  = srcSel[2] ? extEdge : tick[srcSel[1:0]];
  assign strobe.clearReq = regClr | anyClr;
  assign strobe.regClear = regClr;

  always_ff @(posedge clk) begin
    if (!rstN) syncClrOut <= 1'b0;
    else syncClrOut <= regClr & syncEn;
  end

  // R10: outgoing sync clear only follows a cycle with sync operation on
  assert_sync_out_gated_R10: assert property (@(posedge clk) disable iff (!rstN)
    syncClrOut |-> $past(syncEn));

  // R2: the slowest division pulse always coincides with the faster ones
  assert_prescale_nest_R2: assert property (@(posedge clk) disable iff (!rstN)
    tick[NUM_INT-1] |-> (tick[1] && tick[NUM_INT-2]));

  // R3: rising-only external counting never fires on two adjacent cycles
  assert_ext_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel[2] && edgeSel == 2'b00 && strobe.countEn && !cfgWrEn)
      |=> !strobe.countEn);
endmodule

// File: rtl/tmr_cnt_dp.sv
`timescale 1ns/1ps
module tmr_cnt_dp
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  output logic [CNT_W-1:0] cntVal
);
  always_ff @(posedge clk) begin
    if (!rstN)               cntVal <= '0;
    else if (strobe.clearReq) cntVal <= '0;
    else if (strobe.countEn)  cntVal <= cntVal + 1'b1;
  end

  // R9: a clear always lands on zero
  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearReq |=> (cntVal == '0));

  // R5: an increment steps by one modulo the width
  assert_step_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countEn && !strobe.clearReq) |=> (cntVal == CNT_W'($past(cntVal) + 1'b1)));

  // R1: without an enable or a clear the count holds
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.countEn && !strobe.clearReq) |=> $stable(cntVal));
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_EXT = 4,
  parameter int NUM_GR  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [7:0]         cfgWrData,
  input  logic               syncEn,
  input  logic [NUM_EXT-1:0] extClk,
  input  logic [NUM_GR-1:0]  matchEvt,
  input  logic [1:0]         bufMode,
  input  logic               syncClrIn,
  output logic [CNT_W-1:0]   cntVal,
  output logic               syncClrOut
);
  tmrStrobe_t strobe;

  tmr_ctrl #(.NUM_INT(4), .NUM_EXT(NUM_EXT), .NUM_GR(NUM_GR)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .syncEn(syncEn), .extClk(extClk), .matchEvt(matchEvt), .bufMode(bufMode),
    .syncClrIn(syncClrIn), .strobe(strobe), .syncClrOut(syncClrOut)
  );

  tmr_cnt_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cntVal(cntVal)
  );
endmodule

// File: tb/tmr_channel_tb.sv
`timescale 1ns/1ps
module tmr_channel_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic        cfgWrEn = 0;
  logic [7:0]  cfgWrData = 0;
  logic        syncEn = 0;
  logic [3:0]  extClk = 0;
  logic [3:0]  matchEvt = 0;
  logic [1:0]  bufMode = 0;
  logic        syncClrIn = 0;
  logic [15:0] cntVal;
  logic        syncClrOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    bit          isOut;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  always #2 clk = ~clk;

  tmr_channel u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .syncEn(syncEn), .extClk(extClk), .matchEvt(matchEvt), .bufMode(bufMode),
    .syncClrIn(syncClrIn), .cntVal(cntVal), .syncClrOut(syncClrOut)
  );

  // monitor: compares queued expectations just after each falling edge
  always @(negedge clk) begin
    #1;
    while (sbq.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sbq.pop_front();
      act = it.isOut ? {15'd0, syncClrOut} : cntVal;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%0h expected=%0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expCnt(input logic [15:0] v, input string tag);
    sbq.push_back('{1'b0, v, tag});
  endtask

  task automatic expOut(input logic v, input string tag);
    sbq.push_back('{1'b1, {15'd0, v}, tag});
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCfg(input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 0;
  endtask

  task automatic rateCheck(input logic [7:0] d, input int inc, input string tag);
    logic [15:0] v0;
    writeCfg(d);
    v0 = cntVal;
    cyc(64);
    expCnt(v0 + 16'(inc), tag);
  endtask

  task automatic pulsePin(input int pin, input int n);
    repeat (n) begin
      extClk[pin] = 1; cyc(4);
      extClk[pin] = 0; cyc(4);
    end
  endtask

  // counting every cycle at /1; one-cycle strobe, then two samples
  task automatic evtTry(input logic [3:0] ev, input logic sIn, input bit clr,
                        input bit outExp, input string tag);
    logic [15:0] v;
    @(negedge clk);
    v = cntVal;
    matchEvt = ev; syncClrIn = sIn;
    @(negedge clk);
    matchEvt = 0; syncClrIn = 0;
    expCnt(clr ? 16'd0 : v + 16'd1, tag);
    expOut(outExp, {tag, " R10 out"});
    @(negedge clk);
    expCnt(clr ? 16'd1 : v + 16'd2, tag);
    expOut(1'b0, {tag, " R10 width"});
  endtask

  initial begin
    #(150000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v0;
    cyc(3);
    expCnt(16'd0, "R1 reset");
    expOut(1'b0, "R1 reset out");
    rstN = 1;
    @(negedge clk);
    matchEvt = 4'hF; syncClrIn = 1; syncEn = 1;
    @(negedge clk);
    matchEvt = 0; syncClrIn = 0; syncEn = 0;
    expCnt(16'd2, "R1 default no clear");
    cyc(65533);
    expCnt(16'hFFFF, "R5 top");
    cyc(1);
    expCnt(16'h0000, "R5 wrap");

    rateCheck(8'b000_00_001, 16, "R2 div4");
    rateCheck(8'b000_01_010, 4, "R2 div16 R4 falling internal");
    rateCheck(8'b000_00_011, 1, "R2 div64");
    rateCheck(8'b000_10_000, 64, "R2 div1 R4 both internal");

    writeCfg(8'b000_00_110);
    cyc(4);
    v0 = cntVal;
    extClk[2] = 1;
    cyc(1); expCnt(v0, "R11 edge1");
    cyc(1); expCnt(v0, "R11 edge2");
    cyc(1); expCnt(v0 + 16'd1, "R11 edge3");
    extClk[2] = 0; cyc(4);
    expCnt(v0 + 16'd1, "R4 rising ignores fall");
    pulsePin(0, 3);
    expCnt(v0 + 16'd1, "R3 unselected pin");
    pulsePin(2, 2);
    expCnt(v0 + 16'd3, "R3 pin C rising");

    writeCfg(8'b000_01_110);
    v0 = cntVal;
    pulsePin(2, 2);
    expCnt(v0 + 16'd2, "R4 falling");
    writeCfg(8'b000_10_111);
    v0 = cntVal;
    pulsePin(3, 3);
    pulsePin(1, 2);
    expCnt(v0 + 16'd6, "R4 both pin D");

    writeCfg(8'b001_00_000);
    evtTry(4'b0010, 0, 0, 0, "R6 A sel B evt");
    evtTry(4'b0001, 0, 1, 0, "R6 R9 A clear");
    writeCfg(8'b010_00_000);
    evtTry(4'b0001, 0, 0, 0, "R6 B sel A evt");
    evtTry(4'b0010, 0, 1, 0, "R6 B clear");
    writeCfg(8'b100_00_000);
    evtTry(4'b1111, 1, 0, 0, "R6 never clear 100");
    writeCfg(8'b101_00_000);
    bufMode = 2'b01;
    evtTry(4'b0100, 0, 0, 0, "R7 C buffered");
    bufMode = 2'b00;
    evtTry(4'b0100, 0, 1, 0, "R7 C clear");
    writeCfg(8'b110_00_000);
    bufMode = 2'b10;
    evtTry(4'b1000, 0, 0, 0, "R7 D buffered");
    bufMode = 2'b01;
    evtTry(4'b1000, 0, 1, 0, "R7 D clear C buffered");
    bufMode = 2'b00;

    writeCfg(8'b011_00_000);
    syncEn = 0;
    evtTry(4'b0000, 1, 0, 0, "R8 sync disabled");
    syncEn = 1;
    evtTry(4'b0000, 1, 1, 0, "R8 R10 sync clear no echo");
    writeCfg(8'b111_00_000);
    evtTry(4'b0001, 1, 1, 0, "R8 sync 111");

    writeCfg(8'b001_00_000);
    evtTry(4'b0001, 0, 1, 1, "R10 pulse out");
    syncEn = 0;
    evtTry(4'b0001, 0, 1, 0, "R10 no pulse when disabled");

    cyc(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule